// File: doc/BRIEF.md
# Handshaked Serial Byte Transmitter

This block sends one byte at a time on a single serial line that rests high. Each byte goes out as a frame of ten symbols. The frame opens with a low start symbol, carries the eight data bits with the least significant bit first, and closes with a high stop symbol. The length of a symbol is a whole number of system clocks, set by the clock frequency and baud rate parameters. The defaults, 50 MHz and 9600 baud, give 5208 clocks per symbol.

The requester raises `req` and holds it with `byte_in` valid. The block takes the byte and sends the frame. When the stop symbol has finished, it raises `ack` and keeps it high for as long as `req` stays high. Once the requester drops `req`, the block lowers `ack` and returns to idle, ready for the next byte. A new request made in that idle cycle starts a new frame straight after the previous one.

Top module: `serial_tx_hs`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle after that edge: `tx_out` is 1 and `ack` is 0. This also applies in the middle of a frame.
- R2: In idle with `req` low, `tx_out` stays 1 and no frame begins.
- R3: If `req` is sampled high in idle, `tx_out` goes to 0 after that edge and stays at 0 for exactly P = CLK_HZ/BAUD clock cycles. This is the start symbol.
- R4: After the start symbol, the 8 bits of the captured byte follow, bit 0 first. Each bit lasts exactly P cycles, and `tx_out` changes only at symbol boundaries.
- R5: After the data bits, `tx_out` is 1 for the P-cycle stop symbol, so a frame is 10·P cycles long.
- R6: The byte is captured in the accept cycle. Changes on `byte_in` after that cycle do not alter the frame being sent.
- R7: `ack` is 0 for the whole frame. It rises at the edge that ends the stop symbol, which is the 10·P-th edge after the accept edge.
- R8: While `ack` is 1 and `req` stays 1, `ack` stays 1 and `tx_out` stays 1. No second frame begins.
- R9: The first edge at which `req` is sampled low while `ack` is 1 clears `ack` and returns the block to idle. A request made in the next cycle starts a new frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Level request to send `byte_in` |
| byte_in | input | DATA_W | Byte to transmit, valid while `req` is raised |
| ack | output | 1 | Frame complete; held until `req` drops |
| tx_out | output | 1 | Serial line, idle high, registered |

## Verification
The assertions check on every cycle the rules that hold at each edge:
- the line rests high in idle;
- an accepted request produces a low line on the next cycle;
- the line changes only on a symbol tick;
- `ack` rises only as the stop symbol ends;
- `ack` holds while `req` is high and clears once `req` drops;
- reset forces idle.

Only the bench scenarios can show the things that need a reference byte or a count of cycles: the exact P-cycle width of every symbol, LSB-first order against the expected byte, immunity of the frame to `byte_in` changes after capture, and frames sent back to back.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEND = 2'd1,
        PH_HOLD = 2'd2
    } phase_t;

    typedef struct packed {
        logic load;
        logic shift;
        logic run;
    } ctl_t;

    localparam int FRAME_EXTRA = 2;

    function automatic int symbol_clocks(input int clk_hz, input int baud);
        return clk_hz / baud;
    endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV = 5208
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data,
    output logic              line
);
    localparam int FW = DATA_W + sertx_pkg::FRAME_EXTRA;

    logic [FW-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '1;
        end else if (load) begin
            frame_q <= {1'b1, data, 1'b0};
        end else if (shift) begin
            frame_q <= {1'b1, frame_q[FW-1:1]};
        end
    end

    assign line = frame_q[0];
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int FRAME_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic tick,
    output ctl_t ctl,
    output logic ack,
    output logic busy,
    output logic idle
);
    localparam int BC_W = $clog2(FRAME_W);
    localparam logic [BC_W-1:0] LAST_SYM = BC_W'(FRAME_W - 1);

    phase_t ph_q, ph_d;
    logic [BC_W-1:0] sym_q, sym_d;

    always_comb begin
        ph_d      = ph_q;
        sym_d     = sym_q;
        ctl.load  = 1'b0;
        ctl.shift = 1'b0;
        ctl.run   = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (req) begin
                    ctl.load = 1'b1;
                    sym_d    = '0;
                    ph_d     = PH_SEND;
                end
            end
            PH_SEND: begin
                ctl.run = 1'b1;
                if (tick) begin
                    ctl.shift = 1'b1;
                    if (sym_q == LAST_SYM) begin
                        ph_d = PH_HOLD;
                    end else begin
                        sym_d = sym_q + 1'b1;
                    end
                end
            end
            PH_HOLD: begin
                if (!req) begin
                    ph_d = PH_IDLE;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            sym_q <= '0;
        end else begin
            ph_q  <= ph_d;
            sym_q <= sym_d;
        end
    end

    assign ack  = (ph_q == PH_HOLD);
    assign busy = (ph_q == PH_SEND);
    assign idle = (ph_q == PH_IDLE);
endmodule

// File: rtl/serial_tx_hs.sv
module serial_tx_hs
    import sertx_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] byte_in,
    output logic              ack,
    output logic              tx_out
);
    localparam int DIV     = symbol_clocks(CLK_HZ, BAUD);
    localparam int FRAME_W = DATA_W + FRAME_EXTRA;

    ctl_t ctl;
    logic tick;
    logic busy;
    logic idle;

    sertx_fsm #(.FRAME_W(FRAME_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .tick  (tick),
        .ctl   (ctl),
        .ack   (ack),
        .busy  (busy),
        .idle  (idle)
    );

    sertx_baud #(.DIV(DIV)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctl.load),
        .run   (ctl.run),
        .tick  (tick)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctl.load),
        .shift (ctl.shift),
        .data  (byte_in),
        .line  (tx_out)
    );
endmodule

// File: rtl/serial_tx_hs_checker.sv
module serial_tx_hs_checker (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic tx,
    input logic ack,
    input logic busy,
    input logic idle,
    input logic tick
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (tx && !ack && idle));

    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> tx);

    p_accept_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req) |=> (!tx && busy));

    p_tick_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(tx));

    p_ack_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> ($past(busy) && $past(tick) && tx));

    p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> (ack && tx));

    p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> (!ack && idle));
endmodule

bind serial_tx_hs serial_tx_hs_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .tx    (tx_out),
    .ack   (ack),
    .busy  (busy),
    .idle  (idle),
    .tick  (tick)
);

// File: tb/serial_tx_hs_test.sv
`timescale 1ns/1ps
module serial_tx_hs_test;
    localparam int CLK_HZ = 400;
    localparam int BAUD   = 50;
    localparam int P      = CLK_HZ / BAUD;
    localparam int DW     = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic req;
    logic [DW-1:0] byte_in;
    logic ack;
    logic tx_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    serial_tx_hs #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .byte_in(byte_in),
        .ack(ack), .tx_out(tx_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Drive a request and check every cycle of the frame; optionally corrupt byte_in after capture.
    task automatic send_frame(input logic [DW-1:0] d, input bit corrupt);
        logic [9:0] fr;
        fr = {1'b1, d, 1'b0};
        req = 1'b1;
        byte_in = d;
        @(posedge clk);
        for (int s = 0; s < 10; s++) begin
            bit ok_tx = 1'b1;
            bit ok_ack = 1'b1;
            int bad = fr[s];
            for (int c = 0; c < P; c++) begin
                @(negedge clk);
                if (tx_out !== fr[s]) begin ok_tx = 1'b0; bad = tx_out; end
                if (ack !== 1'b0) ok_ack = 1'b0;
                if (corrupt && s == 1 && c == 0) byte_in = ~d;
            end
            if (s == 0)      check(ok_tx, "R3 start symbol", bad, fr[s]);
            else if (s == 9) check(ok_tx, "R5 stop symbol", bad, fr[s]);
            else if (corrupt) check(ok_tx, "R6 captured data bit", bad, fr[s]);
            else             check(ok_tx, "R4 data bit", bad, fr[s]);
            check(ok_ack, "R7 ack low in frame", 1, 0);
        end
        @(negedge clk);
        check(ack === 1'b1, "R7 ack at end of stop", ack, 1);
    endtask

    task automatic hold_release(input int n);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ack !== 1'b1 || tx_out !== 1'b1) ok = 1'b0;
        end
        check(ok, "R8 ack held while req high", {ack, tx_out}, 2'b11);
        req = 1'b0;
        #1 check(ack === 1'b1, "R9 ack before req sampled", ack, 1);
        @(negedge clk);
        check(ack === 1'b0, "R9 ack cleared", ack, 0);
    endtask

    task automatic idle_line(input int n);
        bit ok = 1'b1;
        req = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_out !== 1'b1 || ack !== 1'b0) ok = 1'b0;
        end
        check(ok, "R2 idle line high", tx_out, 1);
    endtask

    task automatic reset_mid_frame();
        req = 1'b1;
        byte_in = 8'h00;
        repeat (3 * P) @(negedge clk);
        check(tx_out === 1'b0, "R1 precondition mid frame", tx_out, 0);
        rst_n = 1'b0;
        req = 1'b0;
        @(negedge clk);
        check(tx_out === 1'b1 && ack === 1'b0, "R1 reset mid frame", {tx_out, ack}, 2'b10);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        req = 1'b0;
        byte_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tx_out === 1'b1 && ack === 1'b0, "R1 reset state", {tx_out, ack}, 2'b10);
        rst_n = 1'b1;
        idle_line(20);
        send_frame(8'h68, 1'b0);
        hold_release(5);
        idle_line(4);
        send_frame(8'hA5, 1'b1);
        hold_release(1);
        // back to back: request in the first idle cycle
        send_frame(8'h00, 1'b0);
        hold_release(0);
        send_frame(8'hFF, 1'b0);
        hold_release(2);
        send_frame(8'h01, 1'b0);
        hold_release(3);
        reset_mid_frame();
        idle_line(3 * P);
        send_frame(8'h80, 1'b0);
        hold_release(1);
        finish_run();
    end
endmodule